// File: doc/BRIEF.md
# Conference Mixing Engine

This block mixes linear PCM for a time-division bus of 32 channels into as many as 10 separate conferences. In each slot a timebase supplies one signed 14-bit linear sample together with the slot index and two strobes. The first strobe marks the start of the slot and the second marks its middle. For each channel, the block returns the sum of every other member of that channel's conference. The channel's own contribution is always left out, so no listener hears itself.

A configuration store holds one entry per channel, written through a simple write port. Each entry gives the channel's mode (disconnected, conference member or transparent), its conference number, its attenuation step and its noise-gate threshold. It also sets a tone flag for the conference and can clear that conference's accumulator.

The accumulator holds a running sum. When a talker's new sample arrives it replaces that talker's previous contribution. At the mid-slot strobe, the listener's output is formed as the running sum minus the listener's own stored sample, saturated to 14 bits.

Top module: `conf_mix_engine`

## Requirements
- R1: At the slot strobe for channel n, a conference member's conditioned sample replaces its previous contribution in its conference sum. On the clock after the mid-slot strobe, `samp_out` holds that sum minus the member's own latest conditioned sample.
- R2: A conference sum holds only the contributions of channels whose mode is conference (mode code 01) with that conference number.
- R3: A transparent channel (mode code 10) outputs its own conditioned sample from the current slot. It is never added to any sum, and tone never replaces it.
- R4: A disconnected channel (mode code 00 or 11) contributes nothing and outputs 0 with `ovf_mark` low.
- R5: The noise-gate code `cfg_ns` works as follows. 00 disables the gate; 01, 10 and 11 force to 0 any sample whose magnitude is below 18, 32 or 64 LSB respectively. Gating is applied before attenuation.
- R6: The attenuation code `cfg_att` works as follows. 00 and 11 pass the sample unchanged, 01 gives floor(x*23/32) (about -3 dB), and 10 gives an arithmetic shift right by one (-6 dB).
- R7: Bit c of `ovf_flags` is high while conference c's sum lies outside the range -8192..8191. `ovf_mark` is high with a member's output when its conference is flagged.
- R8: A member's output is saturated to the range -8192..8191.
- R9: The tone inputs are sampled only at the slot strobe of slot 0. While the latched request is high, members of conferences whose tone flag is set output +819 if the latched square-wave level is 1, and -819 if it is 0.
- R10: Writing a channel's entry removes its old contribution from its old conference and zeroes its stored sample. A conference-mode write with `cfg_start` set clears that conference's sum and stores `cfg_tone` as the conference's tone flag.
- R11: After reset, `samp_out` is 0, `ovf_mark` is 0, `ovf_flags` is 0 and every channel is disconnected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_go | input | 1 | Slot-start strobe; captures `samp_in` for channel `slot_idx` |
| half_go | input | 1 | Mid-slot strobe; produces the output for channel `slot_idx` |
| slot_idx | input | 5 | Current channel slot, held constant through the slot |
| samp_in | input | 14 | Signed linear input sample |
| tone_req | input | 1 | Tone request, latched at slot 0 |
| tone_sq | input | 1 | Square-wave tone level, latched at slot 0 |
| cfg_we | input | 1 | Configuration write enable |
| cfg_chan | input | 5 | Channel being written |
| cfg_mode | input | 2 | 00 off, 01 conference, 10 transparent, 11 off |
| cfg_conf | input | 4 | Conference number 0..9 |
| cfg_att | input | 2 | Attenuation code |
| cfg_ns | input | 2 | Noise-gate code |
| cfg_tone | input | 1 | Conference tone flag |
| cfg_start | input | 1 | Clear the conference sum on this write |
| samp_out | output | 14 | Signed linear output sample |
| ovf_mark | output | 1 | Conference overflow marker for the current output |
| ovf_flags | output | 10 | Per-conference overflow flags |

## Verification
Conference sums and overflow flags change on the clock edge that captures `slot_go`, and are visible from the next cycle. `samp_out` and `ovf_mark` change on the edge that captures `half_go` and then hold until the next mid-slot strobe. The bench asserts each strobe for one cycle, starting on a falling edge. It compares outputs and flags on the falling edge after the mid-slot capture, against a running model updated in the same order. Tone inputs are changed in the middle of a frame to confirm that only the value present at slot 0 counts.

// File: rtl/cc_pkg.sv
// Shared sizes, encodings and arithmetic helpers for the conference mixing engine.
package cc_pkg;
    localparam int NCH      = 32;
    localparam int NCONF    = 10;
    localparam int SW       = 14;
    localparam int CH_W     = $clog2(NCH);
    localparam int CONF_W   = $clog2(NCONF);
    localparam int ACC_W    = SW + CH_W + 1;
    localparam int LIN_MAX  = 2 ** (SW - 1) - 1;
    localparam int LIN_MIN  = -(2 ** (SW - 1));
    localparam int TONE_LVL = LIN_MAX / 10;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_CONF  = 2'b01,
        MODE_PASS  = 2'b10,
        MODE_SPARE = 2'b11
    } mode_e;

    typedef struct packed {
        mode_e             mode;
        logic [CONF_W-1:0] conf;
        logic [1:0]        att;
        logic [1:0]        ns;
    } chan_cfg_t;

    // Sign-extend a linear sample to accumulator width.
    function automatic logic signed [ACC_W-1:0] sx(input logic signed [SW-1:0] v);
        return {{(ACC_W-SW){v[SW-1]}}, v};
    endfunction

    // Clamp an accumulator-width value into the linear sample range.
    function automatic logic signed [SW-1:0] sat_lin(input logic signed [ACC_W-1:0] v);
        if (v > ACC_W'(LIN_MAX))      return SW'(LIN_MAX);
        else if (v < ACC_W'(LIN_MIN)) return SW'(LIN_MIN);
        else                          return SW'(v);
    endfunction
endpackage

// File: rtl/cc_sample_cond.sv
// Per-sample conditioning: noise gate, then stepped attenuation.
// Assumes SW >= 13 so that one threshold step is 2**(SW-13) LSB.
module cc_sample_cond
    import cc_pkg::*;
(
    input  logic signed [SW-1:0] din,
    input  logic [1:0]           att,
    input  logic [1:0]           ns,
    output logic signed [SW-1:0] dout
);
    localparam int STEP_SH = SW - 13;

    logic signed [SW:0]   wide;
    logic [SW:0]          mag;
    logic [SW:0]          thr;
    logic signed [SW-1:0] gated;
    logic signed [SW+5:0] gx;
    logic signed [SW+5:0] prod;

    // Magnitude, threshold selection and gating.
    always_comb begin
        wide = {din[SW-1], din};
        mag  = (wide < 0) ? unsigned'(-wide) : unsigned'(wide);
        case (ns)
            2'b01:   thr = (SW+1)'(9)  << STEP_SH;
            2'b10:   thr = (SW+1)'(16) << STEP_SH;
            2'b11:   thr = (SW+1)'(32) << STEP_SH;
            default: thr = '0;
        endcase
        gated = (mag < thr) ? '0 : din;
    end

    // Attenuation by 23/32, by one half, or none.
    always_comb begin
        gx   = {{6{gated[SW-1]}}, gated};
        prod = gx * signed'((SW+6)'(23));
        case (att)
            2'b01:   dout = SW'(prod >>> 5);
            2'b10:   dout = gated >>> 1;
            default: dout = gated;
        endcase
    end
endmodule

// File: rtl/cc_chan_cfg.sv
// Per-channel configuration store plus per-conference tone flags.
// One write port, one read port addressed by the current slot, and an
// old-entry read of the channel being written (used to retire its contribution).
module cc_chan_cfg
    import cc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_chan,
    input  chan_cfg_t         wr_entry,
    input  logic              wr_tone,
    input  logic [CH_W-1:0]   rd_chan,
    output chan_cfg_t         rd_entry,
    output mode_e             old_mode,
    output logic [CONF_W-1:0] old_conf,
    output logic [NCONF-1:0]  conf_tone
);
    chan_cfg_t tbl [NCH];

    // Table write; reset leaves every channel disconnected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) tbl[i] <= '0;
        end else if (wr_en) begin
            tbl[wr_chan] <= wr_entry;
        end
    end

    // Conference tone flags follow each conference-mode write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conf_tone <= '0;
        end else if (wr_en && wr_entry.mode == MODE_CONF && 32'(wr_entry.conf) < NCONF) begin
            conf_tone[wr_entry.conf] <= wr_tone;
        end
    end

    assign rd_entry = tbl[rd_chan];
    assign old_mode = tbl[wr_chan].mode;
    assign old_conf = tbl[wr_chan].conf;
endmodule

// File: rtl/cc_tone_frame.sv
// Latches the tone request and square-wave level once per frame (slot 0).
module cc_tone_frame
    import cc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_go,
    input  logic                 tone_req,
    input  logic                 tone_sq,
    output logic                 tone_act,
    output logic signed [SW-1:0] tone_val
);
    logic tone_pos;

    // Frame-aligned capture of both tone inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tone_act <= 1'b0;
            tone_pos <= 1'b0;
        end else if (frame_go) begin
            tone_act <= tone_req;
            tone_pos <= tone_sq;
        end
    end

    assign tone_val = tone_pos ? SW'(TONE_LVL) : -SW'(TONE_LVL);

    a_r9_tone_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_go |=> ($stable(tone_act) && $stable(tone_pos)));
endmodule

// File: rtl/conf_mix_engine.sv
// Conference mixing engine top. Keeps a running sum per conference and the
// latest conditioned sample per channel; each listener gets sum minus own.
// Assumes slot_idx is stable through a slot, the strobes are single-cycle,
// and configuration writes never coincide with either strobe.
module conf_mix_engine
    import cc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slot_go,
    input  logic                 half_go,
    input  logic [4:0]           slot_idx,
    input  logic signed [13:0]   samp_in,
    input  logic                 tone_req,
    input  logic                 tone_sq,
    input  logic                 cfg_we,
    input  logic [4:0]           cfg_chan,
    input  logic [1:0]           cfg_mode,
    input  logic [3:0]           cfg_conf,
    input  logic [1:0]           cfg_att,
    input  logic [1:0]           cfg_ns,
    input  logic                 cfg_tone,
    input  logic                 cfg_start,
    output logic signed [13:0]   samp_out,
    output logic                 ovf_mark,
    output logic [9:0]           ovf_flags
);
    logic signed [ACC_W-1:0] acc  [NCONF];
    logic signed [SW-1:0]    hist [NCH];

    chan_cfg_t               scfg;
    chan_cfg_t               wentry;
    mode_e                   old_mode;
    logic [CONF_W-1:0]       old_conf;
    logic [NCONF-1:0]        conf_tone;
    logic signed [SW-1:0]    cond_s;
    logic                    tone_act;
    logic signed [SW-1:0]    tone_val;
    logic                    s_valid;
    logic signed [ACC_W-1:0] acc_rd;
    logic signed [ACC_W-1:0] mix;

    assign wentry = '{mode: mode_e'(cfg_mode), conf: cfg_conf, att: cfg_att, ns: cfg_ns};

    cc_chan_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_chan  (cfg_chan),
        .wr_entry (wentry),
        .wr_tone  (cfg_tone),
        .rd_chan  (slot_idx),
        .rd_entry (scfg),
        .old_mode (old_mode),
        .old_conf (old_conf),
        .conf_tone(conf_tone)
    );

    cc_sample_cond u_cond (
        .din (samp_in),
        .att (scfg.att),
        .ns  (scfg.ns),
        .dout(cond_s)
    );

    cc_tone_frame u_tone (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_go(slot_go && slot_idx == '0),
        .tone_req(tone_req),
        .tone_sq (tone_sq),
        .tone_act(tone_act),
        .tone_val(tone_val)
    );

    // Sums and stored samples: configuration retirement or talker replacement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCONF; c++) acc[c] <= '0;
            for (int i = 0; i < NCH; i++)   hist[i] <= '0;
        end else if (cfg_we) begin
            if (old_mode == MODE_CONF && 32'(old_conf) < NCONF)
                acc[old_conf] <= acc[old_conf] - sx(hist[cfg_chan]);
            if (cfg_mode == MODE_CONF && cfg_start && 32'(cfg_conf) < NCONF)
                acc[cfg_conf] <= '0;
            hist[cfg_chan] <= '0;
        end else if (slot_go) begin
            if (scfg.mode == MODE_CONF && 32'(scfg.conf) < NCONF) begin
                acc[scfg.conf]  <= acc[scfg.conf] + sx(cond_s) - sx(hist[slot_idx]);
                hist[slot_idx]  <= cond_s;
            end else if (scfg.mode == MODE_PASS) begin
                hist[slot_idx]  <= cond_s;
            end
        end
    end

    // Listener mix: own conference sum minus own latest sample.
    always_comb begin
        s_valid = scfg.mode == MODE_CONF && 32'(scfg.conf) < NCONF;
        acc_rd  = s_valid ? acc[scfg.conf] : '0;
        mix     = acc_rd - sx(hist[slot_idx]);
    end

    // Per-conference overflow flags from the running sums.
    for (genvar c = 0; c < NCONF; c++) begin : g_ovf
        assign ovf_flags[c] = (acc[c] > ACC_W'(LIN_MAX)) || (acc[c] < ACC_W'(LIN_MIN));
    end

    // Output register, loaded at the mid-slot strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_out <= '0;
            ovf_mark <= 1'b0;
        end else if (half_go) begin
            if (s_valid) begin
                samp_out <= (tone_act && conf_tone[scfg.conf]) ? tone_val : sat_lin(mix);
                ovf_mark <= ovf_flags[scfg.conf];
            end else if (scfg.mode == MODE_PASS) begin
                samp_out <= hist[slot_idx];
                ovf_mark <= 1'b0;
            end else begin
                samp_out <= '0;
                ovf_mark <= 1'b0;
            end
        end
    end

    a_r10_cfg_apart: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> (!slot_go && !half_go));
    a_r4_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (half_go && (scfg.mode == MODE_OFF || scfg.mode == MODE_SPARE)) |=> (samp_out == '0 && !ovf_mark));
    a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_go && !cfg_we) |=> $stable(ovf_flags));
    a_r1_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !half_go |=> ($stable(samp_out) && $stable(ovf_mark)));
    a_r3_pass_unmarked: assert property (@(posedge clk) disable iff (!rst_n)
        (half_go && scfg.mode == MODE_PASS) |=> !ovf_mark);
endmodule

// File: tb/conf_mix_engine_bench.sv
module conf_mix_engine_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_go = 0, half_go = 0;
    logic [4:0] slot_idx = '0;
    logic signed [13:0] samp_in = '0;
    logic tone_req = 0, tone_sq = 0;
    logic cfg_we = 0;
    logic [4:0] cfg_chan = '0;
    logic [1:0] cfg_mode = '0;
    logic [3:0] cfg_conf = '0;
    logic [1:0] cfg_att = '0, cfg_ns = '0;
    logic cfg_tone = 0, cfg_start = 0;
    logic signed [13:0] samp_out;
    logic ovf_mark;
    logic [9:0] ovf_flags;

    int total = 0, bad = 0;
    bit done = 0;
    int m_mode[32], m_conf[32], m_att[32], m_ns[32], m_hist[32];
    int m_acc[10];
    bit m_ctone[10];
    bit m_tact = 0, m_tpos = 0;
    int fx[32];
    int last_out[32];

    always #10 clk = ~clk;

    conf_mix_engine u_conf_mix_engine (
        .clk(clk), .rst_n(rst_n), .slot_go(slot_go), .half_go(half_go),
        .slot_idx(slot_idx), .samp_in(samp_in), .tone_req(tone_req), .tone_sq(tone_sq),
        .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_mode(cfg_mode), .cfg_conf(cfg_conf),
        .cfg_att(cfg_att), .cfg_ns(cfg_ns), .cfg_tone(cfg_tone), .cfg_start(cfg_start),
        .samp_out(samp_out), .ovf_mark(ovf_mark), .ovf_flags(ovf_flags)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int cond(int x, int att, int ns);
        int thr = (ns == 1) ? 18 : (ns == 2) ? 32 : (ns == 3) ? 64 : 0;
        int ax = (x < 0) ? -x : x;
        int y = (ax < thr) ? 0 : x;
        if (att == 1) y = (y * 23) >>> 5;
        else if (att == 2) y = y >>> 1;
        return y;
    endfunction

    function automatic int sat(int v);
        return (v > 8191) ? 8191 : (v < -8192) ? -8192 : v;
    endfunction

    function automatic bit ovf(int v);
        return (v > 8191) || (v < -8192);
    endfunction

    task automatic do_cfg(int ch, int mode, int conf, int att, int ns, bit tone, bit start);
        @(negedge clk);
        cfg_we = 1; cfg_chan = 5'(ch); cfg_mode = 2'(mode); cfg_conf = 4'(conf);
        cfg_att = 2'(att); cfg_ns = 2'(ns); cfg_tone = tone; cfg_start = start;
        if (m_mode[ch] == 1) m_acc[m_conf[ch]] -= m_hist[ch];
        if (mode == 1 && start) m_acc[conf] = 0;
        if (mode == 1) m_ctone[conf] = tone;
        m_hist[ch] = 0;
        m_mode[ch] = mode; m_conf[ch] = conf; m_att[ch] = att; m_ns[ch] = ns;
        @(negedge clk);
        cfg_we = 0; cfg_start = 0;
    endtask

    task automatic do_slot(int n, int x);
        int c, e, m;
        string tag;
        logic [9:0] ef;
        @(negedge clk);
        slot_go = 1; slot_idx = 5'(n); samp_in = 14'(x);
        if (n == 0) begin m_tact = tone_req; m_tpos = tone_sq; end
        c = cond(x, m_att[n], m_ns[n]);
        if (m_mode[n] == 1) begin
            m_acc[m_conf[n]] += c - m_hist[n];
            m_hist[n] = c;
        end else if (m_mode[n] == 2) begin
            m_hist[n] = c;
        end
        @(negedge clk);
        slot_go = 0; half_go = 1;
        @(negedge clk);
        half_go = 0;
        m = 0;
        if (m_mode[n] == 1) begin
            m = ovf(m_acc[m_conf[n]]);
            if (m_tact && m_ctone[m_conf[n]]) begin
                e = m_tpos ? 819 : -819; tag = "R9 tone";
            end else begin
                e = sat(m_acc[m_conf[n]] - m_hist[n]);
                tag = ovf(m_acc[m_conf[n]] - m_hist[n]) ? "R8 saturate" : "R1 mix";
            end
        end else if (m_mode[n] == 2) begin
            e = m_hist[n]; tag = "R3 transparent";
        end else begin
            e = 0; tag = "R4 off";
        end
        chk(tag, int'($signed(samp_out)), e);
        last_out[n] = int'($signed(samp_out));
        chk("R7 mark", int'(ovf_mark), m);
        for (int k = 0; k < 10; k++) ef[k] = ovf(m_acc[k]);
        chk("R7 flags", int'(ovf_flags), int'(ef));
    endtask

    task automatic run_frame(int kind, bit flip_sq);
        for (int n = 0; n < 32; n++) begin
            int x;
            if (kind == 0) x = fx[n];
            else if (kind == 1) x = int'($urandom % 160) - 80;
            else x = int'($urandom % 16384) - 8192;
            if (flip_sq && n == 6) tone_sq = ~tone_sq;
            do_slot(n, x);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 32; i++) begin m_mode[i] = 0; m_conf[i] = 0; m_att[i] = 0; m_ns[i] = 0; m_hist[i] = 0; fx[i] = 77; end
        for (int k = 0; k < 10; k++) begin m_acc[k] = 0; m_ctone[k] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11 reset out", int'(samp_out), 0);
        chk("R11 reset mark", int'(ovf_mark), 0);
        chk("R11 reset flags", int'(ovf_flags), 0);
        do_slot(9, 500);   // R11: channel disconnected after reset
        chk("R11 reset channel off", last_out[9], 0);

        // Directed frame set-up
        do_cfg(0, 1, 0, 0, 0, 0, 1);
        do_cfg(1, 1, 0, 0, 0, 0, 0);
        do_cfg(2, 1, 0, 0, 0, 0, 0);
        do_cfg(3, 2, 0, 1, 0, 0, 0);
        do_cfg(4, 1, 1, 0, 0, 0, 1);
        do_cfg(5, 1, 1, 0, 0, 0, 0);
        do_cfg(7, 1, 2, 0, 1, 0, 1);
        do_cfg(8, 1, 2, 0, 0, 0, 0);
        do_cfg(9, 2, 0, 2, 0, 0, 0);
        fx[0] = 100; fx[1] = 200; fx[2] = -50; fx[3] = 320; fx[4] = 1000;
        fx[5] = -300; fx[7] = 17; fx[8] = 5; fx[9] = -7;
        run_frame(0, 0);
        chk("R1 ch2 hears others", last_out[2], 300);
        chk("R2 ch5 hears only conf1", last_out[5], 1000);
        chk("R6 minus3dB", last_out[3], 230);
        chk("R6 minus6dB", last_out[9], -4);
        chk("R5 gated below 18", last_out[8], 0);

        do_cfg(5, 0, 0, 0, 0, 0, 0);
        fx[7] = 18;
        run_frame(0, 0);
        chk("R5 kept at 18", last_out[8], 18);
        chk("R10 removed talker", last_out[4], 0);

        do_cfg(0, 1, 0, 0, 0, 0, 1);
        run_frame(0, 0);
        chk("R10 start clears sum", last_out[2], 150);

        // Overflow and tone
        do_cfg(12, 1, 6, 0, 0, 0, 1);
        do_cfg(13, 1, 6, 0, 0, 0, 0);
        do_cfg(14, 1, 6, 0, 0, 0, 0);
        do_cfg(10, 1, 5, 0, 0, 1, 1);
        do_cfg(11, 1, 5, 0, 0, 1, 0);
        fx[12] = 8000; fx[13] = 8000; fx[14] = 0; fx[10] = 40; fx[11] = 60;
        tone_req = 1; tone_sq = 1;
        run_frame(0, 1);
        chk("R8 saturated high", last_out[14], 8191);
        chk("R7 conf6 flagged", int'(ovf_flags[6]), 1);
        chk("R9 tone positive", last_out[11], 819);
        chk("R3 transparent ignores tone", last_out[3], 230);
        tone_sq = 0;
        run_frame(0, 1);
        chk("R9 tone negative", last_out[11], -819);
        tone_req = 0;
        run_frame(0, 0);
        chk("R9 tone off", last_out[11], 40);

        // Random configurations and samples
        for (int r = 0; r < 12; r++) begin
            bit used[10];
            for (int k = 0; k < 10; k++) used[k] = 0;
            for (int ch = 0; ch < 32; ch++) begin
                int md = int'($urandom % 4);
                int cf = int'($urandom % 10);
                bit st = (md == 1) && !used[cf];
                if (md == 1) used[cf] = 1;
                do_cfg(ch, md, cf, int'($urandom % 4), int'($urandom % 4), 1'($urandom % 2), st);
            end
            for (int f = 0; f < 3; f++) begin
                tone_req = 1'($urandom % 4 == 0);
                tone_sq = 1'($urandom % 2);
                run_frame((f == 0) ? 1 : 2, 1'($urandom % 2));
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule